// File: doc/BRIEF.md
# Fast Kernel-to-User Return State Unit

This block computes the architectural state that a fast return from kernel code to user code installs. The pipeline presents a request for one cycle. With it come the current mode bits, a 16-bit selector base held in a model-specific register, the saved return pointer and the saved flags. The current flags also come in, because they are the starting point when the return runs outside 64-bit mode.

One cycle after the request, the block pulses `done` with a fault code. On a fault, none of the state outputs move. On success, the outputs carry the new state, which the surrounding core copies into its architectural registers:

- the code and stack selectors;
- the forced hidden code-segment base, limit and attributes;
- the instruction pointer;
- the flags;
- the privilege level.

Top module: `fast_return_unit`

## Requirements
- R1: When the system-call enable input is 0, the unit reports fault code 1 (invalid opcode) and leaves every state output unchanged.
- R2: When enable is 1 but protected mode is 0 or the current privilege is not 0, the unit reports fault code 2 (general protection) and leaves every state output unchanged. The enable check takes priority over this one.
- R3: In 64-bit mode with operand size code 2'b10, the unit produces the following:
  - the code selector is (base + 16) OR 3;
  - the 64-bit code flag is 1;
  - the instruction pointer is the full 64-bit saved pointer.
- R4: In every other successful case, the unit produces the following:
  - the code selector is base OR 3;
  - the 64-bit code flag is 0;
  - the instruction pointer is the low 32 bits of the saved pointer, zero-extended.

  This applies to operand size codes 2'b00, 2'b01 and 2'b11, and to any non-64-bit mode.
- R5: On success the stack selector is base + 8, with its low two bits not forced.
- R6: On success the code base is 0, the code limit is 32'hFFFFFFFF and the code DPL is 3.
- R7: On success in 64-bit mode, the flags are built as follows:
  - the low 32 bits come from the saved flags;
  - the upper 32 bits are cleared;
  - bit 16 (resume) and bit 17 (virtual-8086) are cleared.
- R8: On success outside 64-bit mode, the flags equal the current flags with bit 9 (interrupt enable) set.
- R9: On success the privilege output is 3, whatever the low bits of the base.
- R10: `done` is high for exactly the cycle after each request and at no other time. Fault code 0 means success.
- R11: Both selector additions wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle return request |
| call_en | input | 1 | System-call enable |
| prot_mode | input | 1 | Protected mode active |
| long_mode | input | 1 | 64-bit mode active |
| cur_priv | input | 2 | Current privilege level |
| op_size | input | 2 | Operand size: 00=16, 01=32, 10=64, 11 treated as 32 |
| sel_base | input | SEL_W | Return selector base |
| saved_ptr | input | ADDR_W | Saved return pointer |
| saved_flags | input | ADDR_W | Saved flags register |
| cur_flags | input | ADDR_W | Current flags |
| done | output | 1 | Result pulse |
| fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| code_sel | output | SEL_W | New code selector |
| stack_sel | output | SEL_W | New stack selector |
| code_base | output | ADDR_W | Hidden code base |
| code_limit | output | 32 | Hidden code limit |
| code_long | output | 1 | Code segment is 64-bit |
| code_dpl | output | 2 | Code segment DPL |
| new_ip | output | ADDR_W | New instruction pointer |
| new_flags | output | ADDR_W | New flags |
| new_priv | output | 2 | New privilege level |

## Verification
The bench builds the unit with its default widths: 16-bit selectors and 64-bit pointers and flags. It sweeps every combination of the following control inputs, 128 control patterns in all:
- enable;
- protected mode;
- 64-bit mode;
- the four privilege levels;
- the four operand-size codes.

Each control pattern is run against several data patterns. These include bases whose low bits are set and bases close to 16'hFFFF, so that wrap-around and the unforced stack RPL are both exercised. The data patterns also include flags with the resume, virtual-8086 and interrupt bits in both states. Faulting cases are interleaved with successful ones, so the hold-on-fault rule is checked against a state that differs from reset.

// File: rtl/fast_return_unit.sv
module fast_return_unit #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              call_en,
  input  logic              prot_mode,
  input  logic              long_mode,
  input  logic [1:0]        cur_priv,
  input  logic [1:0]        op_size,
  input  logic [SEL_W-1:0]  sel_base,
  input  logic [ADDR_W-1:0] saved_ptr,
  input  logic [ADDR_W-1:0] saved_flags,
  input  logic [ADDR_W-1:0] cur_flags,
  output logic              done,
  output logic [1:0]        fault,
  output logic [SEL_W-1:0]  code_sel,
  output logic [SEL_W-1:0]  stack_sel,
  output logic [ADDR_W-1:0] code_base,
  output logic [31:0]       code_limit,
  output logic              code_long,
  output logic [1:0]        code_dpl,
  output logic [ADDR_W-1:0] new_ip,
  output logic [ADDR_W-1:0] new_flags,
  output logic [1:0]        new_priv
);
  localparam int HALF_W = 32;
  localparam int BIT_IF = 9;
  localparam int BIT_RF = 16;
  localparam int BIT_VM = 17;
  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_UD   = 2'd1;
  localparam logic [1:0] FLT_GP   = 2'd2;
  localparam logic [SEL_W-1:0] SS_OFS = SEL_W'(8);
  localparam logic [SEL_W-1:0] CS_OFS = SEL_W'(16);
  localparam logic [SEL_W-1:0] RPL3   = SEL_W'(3);

  logic [1:0]        chk;
  logic              to_long;
  logic [SEL_W-1:0]  cs_nxt;
  logic [ADDR_W-1:0] ip_nxt, fl_nxt, fl_long;

  assign chk = !call_en ? FLT_UD :
               (!prot_mode || cur_priv != 2'd0) ? FLT_GP : FLT_NONE;
  assign to_long = long_mode && (op_size == 2'b10);
  assign cs_nxt  = (to_long ? sel_base + CS_OFS : sel_base) | RPL3;
  assign ip_nxt  = to_long ? saved_ptr
                           : {{(ADDR_W-HALF_W){1'b0}}, saved_ptr[HALF_W-1:0]};

  always_comb begin
    fl_long = {{(ADDR_W-HALF_W){1'b0}}, saved_flags[HALF_W-1:0]};
    fl_long[BIT_RF] = 1'b0;
    fl_long[BIT_VM] = 1'b0;
    fl_nxt = cur_flags;
    fl_nxt[BIT_IF] = 1'b1;
    if (long_mode) fl_nxt = fl_long;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= FLT_NONE;
      code_sel   <= '0;
      stack_sel  <= '0;
      code_base  <= '0;
      code_limit <= '0;
      code_long  <= 1'b0;
      code_dpl   <= 2'd0;
      new_ip     <= '0;
      new_flags  <= '0;
      new_priv   <= 2'd0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        fault <= chk;
        if (chk == FLT_NONE) begin
          code_sel   <= cs_nxt;
          stack_sel  <= sel_base + SS_OFS;
          code_base  <= '0;
          code_limit <= 32'hFFFF_FFFF;
          code_long  <= to_long;
          code_dpl   <= 2'd3;
          new_ip     <= ip_nxt;
          new_flags  <= fl_nxt;
          new_priv   <= 2'd3;
        end
      end
    end
  end

  a_r10_done_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid));
  a_r1_ud_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(call_en)) |-> (fault == FLT_UD));
  a_r2_gp_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_GP) |-> $past(call_en));
  a_r1_fault_holds_ip: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != FLT_NONE) |-> ($stable(new_ip) && $stable(code_sel) && $stable(new_flags)));
  a_r9_priv_three: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_NONE) |-> (new_priv == 2'd3));
  a_r5_stack_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_NONE) |-> (stack_sel == SEL_W'($past(sel_base) + SS_OFS)));
  a_r6_flat_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_NONE) |-> (code_base == '0 && code_limit == 32'hFFFF_FFFF));
  a_r3_long_iff_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_NONE && code_long) |-> $past(long_mode));
endmodule

// File: tb/fast_return_unit_tb.sv
module fast_return_unit_tb;
  logic clk = 0, rst_n = 0, req_valid = 0, call_en = 0, prot_mode = 0, long_mode = 0;
  logic [1:0] cur_priv = 0, op_size = 0;
  logic [15:0] sel_base = 0;
  logic [63:0] saved_ptr = 0, saved_flags = 0, cur_flags = 0;
  logic done, code_long;
  logic [1:0] fault, code_dpl, new_priv;
  logic [15:0] code_sel, stack_sel;
  logic [63:0] code_base, new_ip, new_flags;
  logic [31:0] code_limit;
  int errs = 0, checks = 0;

  logic [15:0] e_cs = 0, e_ss = 0;
  logic [63:0] e_ip = 0, e_fl = 0;
  logic e_long = 0;

  always #2.5 clk = ~clk;

  fast_return_unit u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic en, input logic pm, input logic lm, input logic [1:0] pl,
                     input logic [1:0] os, input logic [15:0] b, input logic [63:0] p,
                     input logic [63:0] sf, input logic [63:0] cf);
    logic [1:0] ef;
    logic tl;
    @(negedge clk);
    req_valid = 1; call_en = en; prot_mode = pm; long_mode = lm; cur_priv = pl;
    op_size = os; sel_base = b; saved_ptr = p; saved_flags = sf; cur_flags = cf;
    ef = !en ? 2'd1 : (!pm || pl != 0) ? 2'd2 : 2'd0;
    tl = lm && os == 2'b10;
    if (ef == 0) begin
      e_cs = tl ? ((b + 16'd16) | 16'd3) : (b | 16'd3);
      e_ss = b + 16'd8;
      e_ip = tl ? p : {32'b0, p[31:0]};
      e_long = tl;
      if (lm) begin
        e_fl = {32'b0, sf[31:0]};
        e_fl[16] = 0; e_fl[17] = 0;
      end else begin
        e_fl = cf; e_fl[9] = 1;
      end
    end
    @(negedge clk);
    req_valid = 0;
    chk("R10 done", done, 1);
    chk(ef == 1 ? "R1 fault" : ef == 2 ? "R2 fault" : "R10 fault", fault, ef);
    chk(tl ? "R3 code_sel R11" : "R4 code_sel R11", code_sel, e_cs);
    chk("R5 stack_sel R11", stack_sel, e_ss);
    chk(tl ? "R3 ip" : "R4 ip", new_ip, e_ip);
    chk("R3 R4 code_long", code_long, e_long);
    chk(lm ? "R7 flags" : "R8 flags", new_flags, e_fl);
    if (ef == 0) begin
      chk("R6 base", code_base, 0);
      chk("R6 limit", code_limit, 32'hFFFF_FFFF);
      chk("R6 dpl", code_dpl, 3);
      chk("R9 priv", new_priv, 3);
    end
    @(negedge clk);
    chk("R10 no done", done, 0);
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] bases [4];
    logic [63:0] ptrs [4];
    logic [63:0] sfl [4];
    logic [63:0] cfl [4];
    bases = '{16'h0010, 16'h0023, 16'hFFF2, 16'hFFFB};
    ptrs  = '{64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0001, 64'h0, 64'h8000_0000_FFFF_FFFF};
    sfl   = '{64'hFFFF_FFFF_0003_0202, 64'h0, 64'h0000_0000_FFFF_FFFF, 64'hA5A5_A5A5_0001_0000};
    cfl   = '{64'h0000_0000_0003_0000, 64'h0000_0000_0000_0202, 64'hFFFF_FFFF_FFFF_FDFF, 64'h0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset done", done, 0);
    chk("R10 reset fault", fault, 0);
    chk("R9 reset priv", new_priv, 0);
    chk("R4 reset ip", new_ip, 0);
    rst_n = 1;
    for (int d = 0; d < 4; d++)
      for (int c = 0; c < 128; c++)
        run(c[0], c[1], c[2], c[4:3], c[6:5], bases[(d + c) % 4], ptrs[(d + c / 7) % 4],
            sfl[(d + c / 3) % 4], cfl[(d + c / 5) % 4]);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule